// File: doc/BRIEF.md
# Timer Compare Output Channel

One compare channel on a free-running up-counter. The counter and the output logic run on a timer clock. Configuration and status belong to a separate CPU clock, and the two clocks need not be related. Each time the counter passes the programmed compare value, the channel raises an event flag. Depending on the selected mode, the same event may also drive the output pin high or low, and the pin keeps that level afterwards. In the direct mode the pin simply copies a programmable output bit. Software uses that mode to park a serial line at its idle level. It then alternates between the set and reset modes to place later edges at precise counter values.

Compare and mode writes cross into the timer domain as one payload over a toggle handshake. A compare match therefore never sees half of an update. The CPU side reads the counter through a resampling path. That path publishes a value only once two consecutive CPU-clock samples agree.

Top module: `tcmp_channel`

## Requirements
- R1: The counter is CNT_W bits wide (16 by default). It starts at 0 after reset, adds one on every timer clock and wraps from all-ones to zero.
- R2: In set mode (control bits [1:0] = 01), the pin is high from the timer edge that ends a cycle in which the counter equals the live compare value.
- R3: In reset mode (control bits [1:0] = 11), the pin is low from that same edge.
- R4: In direct mode (control bits [1:0] = 00 or 10), the pin takes the live output bit (control bit 2) one timer clock after it loads.
- R5: In set or reset mode the pin holds its level on every cycle without a match. Entering either mode, or flipping control bit 1 between them, leaves the pin unchanged until the next match.
- R6: Every match sets the event flag in the CPU domain, whatever the interrupt enable (control bit 3) says. `irq` is high exactly when the flag and the enable are both set.
- R7: A write with `wr_sel` = 2 and `wr_data[0]` = 1 clears the flag. The same write with `wr_data[0]` = 0 leaves the flag unchanged.
- R8: `cnt_rd` shows only values that the counter held within the last few timer cycles. It is updated only when two consecutive CPU samples agree.
- R9: A write with `wr_sel` = 0 (compare) or `wr_sel` = 1 (control) is accepted when `cfg_busy` is low. It raises `cfg_busy` until the timer domain has loaded it. Compare or control writes made while `cfg_busy` is high are ignored.
- R10: After reset the pin is low, the flag is clear, `cfg_busy` is low and `cnt_rd` is 0. The live compare value is all-ones and the mode is direct with output bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_clk | input | 1 | CPU-side clock |
| cpu_rst_n | input | 1 | Synchronous active-low reset, CPU domain |
| tmr_clk | input | 1 | Timer clock |
| tmr_rst_n | input | 1 | Synchronous active-low reset, timer domain |
| wr_en | input | 1 | Register write strobe (CPU domain) |
| wr_sel | input | 2 | 0 compare, 1 control, 2 flag clear |
| wr_data | input | CNT_W | Write data |
| cfg_busy | output | 1 | A configuration transfer is in flight |
| cnt_rd | output | CNT_W | Counter value as seen safely from the CPU domain |
| irq_flag | output | 1 | Match event flag |
| irq | output | 1 | Flag gated by the interrupt enable |
| out_pin | output | 1 | Compare output |

## Verification
The bench first parks the line high in direct mode. It then arms a reset-mode fall and later a set-mode rise, each at a compare value a few hundred counts ahead. Every edge must land exactly one timer cycle after the counter reaches the programmed value. A second compare write is issued while the first is still in flight. A match at the second value would show that busy writes leak through, so it is told apart from a match at the first. A repeated match with the pin already high and the enable off separates flag setting from pin motion and from interrupt gating. Throughout the run, every `cnt_rd` sample is compared with a counter model clocked by the unrelated timer clock, and this comparison covers a wrap.

// File: rtl/tcmp_pkg.sv
// Shared encodings for the timer compare channel.
// Assumes: control payload bit order is {out_bit, mode[1:0]}, irq enable at bit 3.
package tcmp_pkg;
    localparam logic [1:0] SEL_CMP  = 2'd0;
    localparam logic [1:0] SEL_CTL  = 2'd1;
    localparam logic [1:0] SEL_FCLR = 2'd2;

    localparam logic [1:0] MODE_DIRECT = 2'b00;
    localparam logic [1:0] MODE_SET    = 2'b01;
    localparam logic [1:0] MODE_ALT    = 2'b10;
    localparam logic [1:0] MODE_RESET  = 2'b11;

    localparam int CTL_OUT_BIT = 2;
    localparam int CTL_IE_BIT  = 3;
    localparam int XFER_CTL_W  = 3;
endpackage

// File: rtl/tcmp_cfg_xfer.sv
// Toggle-handshake transfer of one configuration word from the CPU
// domain into the timer domain.
// Assumes: ld is only asserted while busy is low; both resets overlap.
module tcmp_cfg_xfer #(
    parameter int              W       = 8,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         cpu_clk,
    input  logic         cpu_rst_n,
    input  logic         tmr_clk,
    input  logic         tmr_rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_data,
    output logic         busy,
    output logic [W-1:0] src_q,
    output logic [W-1:0] dst_q
);
    logic       req_tgl;
    logic [1:0] ack_sync;
    logic [2:0] req_sync;
    logic       ack_tgl;

    // Capture the new word and flip the request toggle.
    always_ff @(posedge cpu_clk) begin
        if (!cpu_rst_n) begin
            src_q   <= RST_VAL;
            req_tgl <= 1'b0;
        end else if (ld) begin
            src_q   <= ld_data;
            req_tgl <= ~req_tgl;
        end
    end

    // Bring the acknowledge toggle back into the CPU domain.
    always_ff @(posedge cpu_clk) begin
        if (!cpu_rst_n) ack_sync <= '0;
        else            ack_sync <= {ack_sync[0], ack_tgl};
    end

    assign busy = req_tgl ^ ack_sync[1];

    // Synchronize the request and load the held word on its edge.
    always_ff @(posedge tmr_clk) begin
        if (!tmr_rst_n) begin
            req_sync <= '0;
            dst_q    <= RST_VAL;
            ack_tgl  <= 1'b0;
        end else begin
            req_sync <= {req_sync[1:0], req_tgl};
            if (req_sync[2] != req_sync[1]) begin
                dst_q   <= src_q;
                ack_tgl <= req_sync[1];
            end
        end
    end
endmodule

// File: rtl/tcmp_cnt_reader.sv
// CPU-domain view of the timer counter: resample the bus each CPU clock
// and publish a value only when two consecutive samples agree.
// Assumes: CPU clock is fast enough for the counter to hold a value for
// at least two CPU samples.
module tcmp_cnt_reader #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_async,
    output logic [W-1:0] cnt_safe
);
    logic [W-1:0] smp_a, smp_b, smp_c;

    // Sample chain across the clock boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_a <= '0;
            smp_b <= '0;
            smp_c <= '0;
        end else begin
            smp_a <= cnt_async;
            smp_b <= smp_a;
            smp_c <= smp_b;
        end
    end

    // Publish only a value that two successive samples agree on.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_safe <= '0;
        else if (smp_b == smp_c) cnt_safe <= smp_b;
    end
endmodule

// File: rtl/tcmp_evt_sync.sv
// Carries a toggle-encoded event from the timer domain into a one-cycle
// pulse in the CPU domain.
// Assumes: events are spaced by more than a few CPU clocks.
module tcmp_evt_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic pulse
);
    logic [2:0] sync_q;

    // Three-stage toggle synchronizer; the last pair detects the change.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], tgl_in};
    end

    assign pulse = sync_q[2] ^ sync_q[1];
endmodule

// File: rtl/tcmp_out_unit.sv
// Timer-domain core: free-running counter, equality compare and the
// output level register driven by the selected mode.
// Assumes: cmp, mode and out_bit only change through the handshake.
module tcmp_out_unit
    import tcmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cmp,
    input  logic [1:0]   mode,
    input  logic         out_bit,
    output logic [W-1:0] cnt,
    output logic         hit_tgl,
    output logic         out_q
);
    logic hit;

    assign hit = (cnt == cmp);

    // Free-running counter, wraps naturally at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // Each match flips the event toggle for the CPU side.
    always_ff @(posedge clk) begin
        if (!rst_n)   hit_tgl <= 1'b0;
        else if (hit) hit_tgl <= ~hit_tgl;
    end

    // Output level: match-driven in set/reset, copied in direct mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else begin
            case (mode)
                MODE_SET:   if (hit) out_q <= 1'b1;
                MODE_RESET: if (hit) out_q <= 1'b0;
                default:    out_q <= out_bit;
            endcase
        end
    end
endmodule

// File: rtl/tcmp_channel.sv
// Top of the compare channel: CPU-side write decode, event flag and
// interrupt gating, plus the clock-crossing pieces around the timer core.
// Assumes: tmr_clk and cpu_clk are unrelated; resets overlap at start.
module tcmp_channel
    import tcmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             cpu_clk,
    input  logic             cpu_rst_n,
    input  logic             tmr_clk,
    input  logic             tmr_rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             cfg_busy,
    output logic [CNT_W-1:0] cnt_rd,
    output logic             irq_flag,
    output logic             irq,
    output logic             out_pin
);
    localparam int             XW      = CNT_W + XFER_CTL_W;
    localparam logic [XW-1:0]  XFER_RST = {{XFER_CTL_W{1'b0}}, {CNT_W{1'b1}}};

    logic             ld;
    logic [XW-1:0]    ld_data;
    logic [XW-1:0]    src_hold;
    logic [XW-1:0]    live_pay;
    logic [CNT_W-1:0] live_cmp;
    logic [1:0]       live_mode;
    logic             live_out_bit;
    logic [CNT_W-1:0] tmr_cnt;
    logic             hit_tgl;
    logic             hit_evt;
    logic             ie_q;
    logic             fclr;

    assign ld = wr_en && !cfg_busy && (wr_sel == SEL_CMP || wr_sel == SEL_CTL);
    assign ld_data = (wr_sel == SEL_CMP)
                   ? {src_hold[XW-1:CNT_W], wr_data}
                   : {wr_data[XFER_CTL_W-1:0], src_hold[CNT_W-1:0]};
    assign fclr = wr_en && (wr_sel == SEL_FCLR) && wr_data[0];

    assign live_cmp     = live_pay[CNT_W-1:0];
    assign live_mode    = live_pay[CNT_W+1:CNT_W];
    assign live_out_bit = live_pay[CNT_W+CTL_OUT_BIT];

    tcmp_cfg_xfer #(.W(XW), .RST_VAL(XFER_RST)) u_xfer (
        .cpu_clk  (cpu_clk),
        .cpu_rst_n(cpu_rst_n),
        .tmr_clk  (tmr_clk),
        .tmr_rst_n(tmr_rst_n),
        .ld       (ld),
        .ld_data  (ld_data),
        .busy     (cfg_busy),
        .src_q    (src_hold),
        .dst_q    (live_pay)
    );

    tcmp_out_unit #(.W(CNT_W)) u_core (
        .clk    (tmr_clk),
        .rst_n  (tmr_rst_n),
        .cmp    (live_cmp),
        .mode   (live_mode),
        .out_bit(live_out_bit),
        .cnt    (tmr_cnt),
        .hit_tgl(hit_tgl),
        .out_q  (out_pin)
    );

    tcmp_cnt_reader #(.W(CNT_W)) u_rd (
        .clk      (cpu_clk),
        .rst_n    (cpu_rst_n),
        .cnt_async(tmr_cnt),
        .cnt_safe (cnt_rd)
    );

    tcmp_evt_sync u_evt (
        .clk   (cpu_clk),
        .rst_n (cpu_rst_n),
        .tgl_in(hit_tgl),
        .pulse (hit_evt)
    );

    // Interrupt enable lives in the CPU domain only.
    always_ff @(posedge cpu_clk) begin
        if (!cpu_rst_n)                  ie_q <= 1'b0;
        else if (ld && wr_sel == SEL_CTL) ie_q <= wr_data[CTL_IE_BIT];
    end

    // Event flag: a match sets it (wins over a clear), write-one clears.
    always_ff @(posedge cpu_clk) begin
        if (!cpu_rst_n)   irq_flag <= 1'b0;
        else if (hit_evt) irq_flag <= 1'b1;
        else if (fclr)    irq_flag <= 1'b0;
    end

    assign irq = irq_flag & ie_q;
endmodule

// File: rtl/tcmp_channel_chk.sv
// Property checker for tcmp_channel, attached by bind below.
// Assumes: mode encodings from tcmp_pkg.
module tcmp_channel_chk
    import tcmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                    cpu_clk,
    input logic                    cpu_rst_n,
    input logic                    tmr_clk,
    input logic                    tmr_rst_n,
    input logic                    wr_en,
    input logic [1:0]              wr_sel,
    input logic                    cfg_busy,
    input logic                    irq,
    input logic                    irq_flag,
    input logic                    out_pin,
    input logic [CNT_W-1:0]        tmr_cnt,
    input logic [CNT_W-1:0]        live_cmp,
    input logic [1:0]              live_mode,
    input logic                    live_out_bit,
    input logic [CNT_W+2:0]        src_hold
);
    p_set_hit_r2: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
        (live_mode == MODE_SET && tmr_cnt == live_cmp) |=> out_pin);

    p_reset_hit_r3: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
        (live_mode == MODE_RESET && tmr_cnt == live_cmp) |=> !out_pin);

    p_direct_follow_r4: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
        (live_mode == MODE_DIRECT || live_mode == MODE_ALT) |=> (out_pin == $past(live_out_bit)));

    p_hold_between_hits_r5: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
        (live_mode[0] && tmr_cnt != live_cmp) |=> $stable(out_pin));

    p_irq_needs_flag_r6: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        irq |-> irq_flag);

    p_busy_write_ignored_r9: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        (cfg_busy && wr_en && wr_sel != SEL_FCLR) |=> $stable(src_hold));
endmodule

bind tcmp_channel tcmp_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .cpu_clk     (cpu_clk),
    .cpu_rst_n   (cpu_rst_n),
    .tmr_clk     (tmr_clk),
    .tmr_rst_n   (tmr_rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .cfg_busy    (cfg_busy),
    .irq         (irq),
    .irq_flag    (irq_flag),
    .out_pin     (out_pin),
    .tmr_cnt     (tmr_cnt),
    .live_cmp    (live_cmp),
    .live_mode   (live_mode),
    .live_out_bit(live_out_bit),
    .src_hold    (src_hold)
);

// File: tb/tb_tcmp_channel.sv
`timescale 1ns/1ps
// Scoreboard bench: expected pin edges are queued by the driver and
// popped by a monitor on the timer clock; a second monitor checks the
// CPU-side counter view against a bench-owned counter model.
module tb_tcmp_channel;
    localparam int W = 10;
    localparam int M = 1 << W;

    logic         cpu_clk = 1'b0;
    logic         tmr_clk = 1'b0;
    logic         cpu_rst_n = 1'b0;
    logic         tmr_rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic         cfg_busy, irq_flag, irq, out_pin;
    logic [W-1:0] cnt_rd;

    tcmp_channel #(.CNT_W(W)) dut (
        .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n),
        .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cfg_busy(cfg_busy), .cnt_rd(cnt_rd),
        .irq_flag(irq_flag), .irq(irq), .out_pin(out_pin)
    );

    always #2 cpu_clk = ~cpu_clk;   // 250 MHz
    always #7 tmr_clk = ~tmr_clk;   // unrelated timer clock

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    int  mcnt   = 0;
    bit  q_lvl[$];
    int  q_cnt[$];
    bit  prev_out = 1'b0;
    bit  rd_on = 1'b0;
    bit  wrapped = 1'b0;
    int  last_rd = 0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Bench counter model, R1 semantics.
    always @(posedge tmr_clk) begin
        if (!tmr_rst_n) mcnt <= 0;
        else            mcnt <= (mcnt + 1) % M;
    end

    // Monitor: every pin change must match the head of the queue.
    always @(negedge tmr_clk) begin
        if (tmr_rst_n && out_pin !== prev_out) begin
            if (q_lvl.size() == 0) begin
                check("R5 unexpected pin edge", int'(out_pin), int'(prev_out));
            end else begin
                bit lv;
                int cv;
                lv = q_lvl.pop_front();
                cv = q_cnt.pop_front();
                check("R2/R3/R4 edge level", int'(out_pin), int'(lv));
                if (cv >= 0) check("R2/R3 edge at match", (mcnt - 1 + M) % M, cv);
            end
        end
        prev_out = out_pin;
    end

    // Monitor: CPU-side counter view must be a recent counter value (R8).
    always @(negedge cpu_clk) begin
        if (rd_on) begin
            int d;
            d = (mcnt - int'(cnt_rd) + M) % M;
            checks++;
            if (d > 4) begin
                fails++;
                $display("FAIL R8 cnt_rd actual=%0d expected_near=%0d", cnt_rd, mcnt);
            end
            if (int'(cnt_rd) < last_rd) wrapped = 1'b1;
            last_rd = int'(cnt_rd);
        end
    end

    task automatic wr(input logic [1:0] s, input int d);
        @(negedge cpu_clk);
        wr_en = 1'b1; wr_sel = s; wr_data = W'(d);
        @(negedge cpu_clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (cfg_busy && n < 1000) begin @(negedge cpu_clk); n++; end
        check("R9 busy clears", int'(cfg_busy), 0);
    endtask

    task automatic expect_edge(input bit lv, input int cv);
        q_lvl.push_back(lv);
        q_cnt.push_back(cv);
    endtask

    task automatic wait_queue(input string req, input int lim);
        int n = 0;
        while (q_lvl.size() != 0 && n < lim) begin @(negedge cpu_clk); n++; end
        check(req, q_lvl.size(), 0);
    endtask

    function automatic int ahead(input int k);
        return (mcnt + k) % M;
    endfunction

    initial begin
        int c1, c2, c3;
        repeat (6) @(negedge tmr_clk);
        @(negedge cpu_clk);
        cpu_rst_n = 1'b1;
        tmr_rst_n = 1'b1;
        @(negedge cpu_clk);
        // R10 reset state
        check("R10 out_pin", int'(out_pin), 0);
        check("R10 irq_flag", int'(irq_flag), 0);
        check("R10 cfg_busy", int'(cfg_busy), 0);
        check("R10 cnt_rd", int'(cnt_rd), 0);
        rd_on = 1'b1;

        // R4: direct mode parks the line high
        expect_edge(1'b1, -1);
        wr(2'd1, 4'b0100);
        wait_idle();
        wait_queue("R4 direct high", 200);
        check("R4 pin high", int'(out_pin), 1);

        // R9: second compare write while busy is dropped; R3 fall at c1
        c1 = ahead(300);
        c2 = (c1 + 100) % M;
        wr(2'd0, c1);
        check("R9 busy after write", int'(cfg_busy), 1);
        wr(2'd0, c2);
        wait_idle();
        wr(2'd2, 1);
        expect_edge(1'b0, c1);
        wr(2'd1, 4'b1011);
        wait_idle();
        check("R5 entering reset mode holds pin", int'(out_pin), 1);
        wait_queue("R3 fall at compare", 8000);
        repeat (12) @(negedge cpu_clk);
        check("R6 flag after match", int'(irq_flag), 1);
        check("R6 irq with enable", int'(irq), 1);

        // R7: write zero keeps flag, write one clears
        wr(2'd2, 0);
        repeat (2) @(negedge cpu_clk);
        check("R7 zero write keeps flag", int'(irq_flag), 1);
        wr(2'd2, 1);
        repeat (2) @(negedge cpu_clk);
        check("R7 flag cleared", int'(irq_flag), 0);
        check("R6 irq low after clear", int'(irq), 0);

        // R5 and R2: switch to set mode, pin waits for the match
        c3 = ahead(400);
        wr(2'd0, c3);
        wait_idle();
        expect_edge(1'b1, c3);
        wr(2'd1, 4'b0001);
        wait_idle();
        repeat (20) @(negedge cpu_clk);
        check("R5 set mode waits for match", int'(out_pin), 0);
        wait_queue("R2 rise at compare", 8000);
        check("R2 pin high", int'(out_pin), 1);

        // R6: repeated match with enable off sets flag, no pin move
        repeat (12) @(negedge cpu_clk);
        wr(2'd2, 1);
        repeat (4) @(negedge cpu_clk);
        check("R7 clear before rematch", int'(irq_flag), 0);
        repeat (M + 40) @(negedge tmr_clk);
        check("R6 flag on rematch", int'(irq_flag), 1);
        check("R6 irq gated off", int'(irq), 0);
        check("R5 pin holds on rematch", int'(out_pin), 1);

        // R5/R3: flip one mode bit back to reset; fall only at match
        wr(2'd1, 4'b0011);
        wait_idle();
        repeat (20) @(negedge cpu_clk);
        check("R5 flip holds pin", int'(out_pin), 1);
        expect_edge(1'b0, c3);
        wait_queue("R3 second fall", 8000);

        // R4: back to direct with bit 0
        wr(2'd1, 4'b0000);
        wait_idle();
        repeat (20) @(negedge cpu_clk);
        check("R4 direct low", int'(out_pin), 0);

        check("R1 counter view wrapped", int'(wrapped), 1);
        rd_on = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #700000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule